// File: doc/BRIEF.md
# Dual-Target Maskable Interrupt Aggregator

This block collects single-cycle event pulses from a crypto subsystem and turns them into two interrupt requests. One goes to the local processor, which has nine source bits. The other goes to a host line, which has five source bits. Each target keeps a sticky raw status word, a mask, a force path, a clear path and a one-bit output-style setting. Software can read the status both before and after the mask is applied.

Integration decides how the event wires map to the source bits. In the usual mapping the local target sees these events:

- context-0 done
- context-1 done
- hash/encrypt error
- DMA transfer done
- DMA transfer queued
- external-memory conflict
- host-wrote-command

The host target sees context done, error, DMA done and processor-wrote-command.

Software reaches the block through a flat register port. A write takes effect on the clock edge. A read returns data combinationally from the current register state.

Each target drives its output from a small state machine with four states:

- **QUIET**: output low.
- **LEVEL**: output high in level style.
- **PULSE**: a one-cycle high in pulse style.
- **HOLD**: pulse style, with masked bits still pending but the output low.

The next state is computed from the style setting and the masked status of the current cycle:

- **Level style**: any state goes to LEVEL when any masked bit is set, and to QUIET otherwise.
- **Pulse style**: any state goes to PULSE when a masked bit is set now that was clear in the previous cycle. Otherwise it goes to HOLD when masked bits remain, and to QUIET when none remain.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all mask, style, raw and masked status registers read 0, and both interrupt outputs are low.
- R2: An event pulse on a source bit sets that target's raw status bit one clock edge later. The bit stays set until it is cleared, whatever the later event activity.
- R3: Writing the clear offset (2) with a 1 in a bit position resets that raw status bit at the write edge. Bits written 0 are left unchanged. If an event on a bit and a clear of the same bit happen in the same cycle, the bit stays set.
- R4: Writing the force offset (1) with a 1 in a bit position sets that raw status bit at the write edge, even when no event occurs.
- R5: The raw status reads at offset 4. The masked status, equal to raw AND mask, reads at offset 5. The mask reads and writes at offset 0, with a 1 enabling a source.
- R6: In level style (style bit 0 = 0 at offset 3), an interrupt output is high exactly in the cycles that follow a cycle with a nonzero masked status. It rises one edge after the raw bit appears, and falls one edge after the masked status becomes empty.
- R7: In pulse style (style bit 0 = 1), an output is high for exactly one cycle after each cycle in which a masked bit becomes newly set. It stays low while the masked set is unchanged. A new event on a bit that is already set gives no pulse.
- R8: Address bit 3 selects the target, with 0 for local and 1 for host. A write to one target's registers leaves the other target's registers and output unchanged.
- R9: The local target holds 9 source bits and the host target holds 5. Write bits above a target's width are ignored and read back as 0.
- R10: The force and clear offsets, and offsets 6 and 7, always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcl_evt_i | input | 9 | Event pulses for the local target |
| hst_evt_i | input | 5 | Event pulses for the host target |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: bit 3 selects the target, bits 2..0 select the offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| lcl_irq_o | output | 1 | Interrupt request to the local processor |
| hst_irq_o | output | 1 | Interrupt request to the host line |

## Verification
The hardest case to reach is an event and a clear that land on the same bit in the same cycle. The bench gets there by raising the event and the clear write strobe in the same half-cycle, so both are sampled at one edge, and then reads the raw status. A second hard case is pulse style with masked bits already pending, where a repeated event must stay silent. The bench builds that state by raising one event, waiting out its pulse, and then firing the same bit again before any clear.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned REG_AW = 4;
    localparam int unsigned OFS_W  = 3;

    localparam logic [OFS_W-1:0] OFS_MASK  = 3'd0;
    localparam logic [OFS_W-1:0] OFS_FORCE = 3'd1;
    localparam logic [OFS_W-1:0] OFS_CLEAR = 3'd2;
    localparam logic [OFS_W-1:0] OFS_STYLE = 3'd3;
    localparam logic [OFS_W-1:0] OFS_RAW   = 3'd4;
    localparam logic [OFS_W-1:0] OFS_MSKD  = 3'd5;

    typedef enum logic [1:0] {
        IRQ_QUIET = 2'd0,
        IRQ_LEVEL = 2'd1,
        IRQ_PULSE = 2'd2,
        IRQ_HOLD  = 2'd3
    } irq_state_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] set_sw,
    input  logic [N-1:0] clr_sw,
    output logic [N-1:0] raw_o
);
    logic [N-1:0] raw_q;

    // Each bit is sticky; a set (event or force) overrides a clear.
    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                raw_q[b] <= 1'b0;
            end else if (evt[b] || set_sw[b]) begin
                raw_q[b] <= 1'b1;
            end else if (clr_sw[b]) begin
                raw_q[b] <= 1'b0;
            end
        end
    end

    assign raw_o = raw_q;
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_agg_pkg::*;
#(
    parameter int unsigned N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] masked,
    input  logic         pulse_style,
    output logic         irq_o
);
    irq_state_e   state_q, state_d;
    logic [N-1:0] prev_q;
    logic         any_set, any_new;

    assign any_set = |masked;
    assign any_new = |(masked & ~prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= masked;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET, IRQ_LEVEL: begin
                if (!pulse_style)  state_d = any_set ? IRQ_LEVEL : IRQ_QUIET;
                else if (any_new)  state_d = IRQ_PULSE;
                else if (any_set)  state_d = IRQ_HOLD;
                else               state_d = IRQ_QUIET;
            end
            IRQ_PULSE, IRQ_HOLD: begin
                if (!pulse_style)  state_d = any_set ? IRQ_LEVEL : IRQ_QUIET;
                else if (any_new)  state_d = IRQ_PULSE;
                else if (any_set)  state_d = IRQ_HOLD;
                else               state_d = IRQ_QUIET;
            end
            default:               state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_LEVEL) || (state_q == IRQ_PULSE);
    end
endmodule

// File: rtl/irq_target.sv
module irq_target
    import irq_agg_pkg::*;
#(
    parameter int unsigned N  = 9,
    parameter int unsigned DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     evt,
    input  logic             sel,
    input  logic             wr,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic [N-1:0]     raw_o,
    output logic [N-1:0]     msk_o,
    output logic             style_o,
    output logic             irq_o
);
    logic [N-1:0] mask_q;
    logic         style_q;
    logic [N-1:0] set_sw, clr_sw, raw, masked;
    logic         wr_hit;

    assign wr_hit = sel && wr;
    assign set_sw = (wr_hit && ofs == OFS_FORCE) ? wdata[N-1:0] : '0;
    assign clr_sw = (wr_hit && ofs == OFS_CLEAR) ? wdata[N-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            style_q <= 1'b0;
        end else if (wr_hit) begin
            if (ofs == OFS_MASK)  mask_q  <= wdata[N-1:0];
            if (ofs == OFS_STYLE) style_q <= wdata[0];
        end
    end

    irq_status_bank #(.N(N)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .set_sw (set_sw),
        .clr_sw (clr_sw),
        .raw_o  (raw)
    );

    assign masked = raw & mask_q;

    irq_out_fsm #(.N(N)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .masked      (masked),
        .pulse_style (style_q),
        .irq_o       (irq_o)
    );

    always_comb begin
        case (ofs)
            OFS_MASK:  rdata = DW'(mask_q);
            OFS_STYLE: rdata = DW'(style_q);
            OFS_RAW:   rdata = DW'(raw);
            OFS_MSKD:  rdata = DW'(masked);
            default:   rdata = '0;
        endcase
    end

    if (N < DW) begin : g_pad
        logic unused_hi;
        assign unused_hi = ^wdata[DW-1:N];
    end

    assign raw_o   = raw;
    assign msk_o   = masked;
    assign style_o = style_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned LCL_N = 9,
    parameter int unsigned HST_N = 5,
    parameter int unsigned DW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LCL_N-1:0]  lcl_evt_i,
    input  logic [HST_N-1:0]  hst_evt_i,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              lcl_irq_o,
    output logic              hst_irq_o
);
    localparam int unsigned TSEL = REG_AW - 1;

    logic [DW-1:0]    lcl_rd, hst_rd;
    logic [LCL_N-1:0] lcl_raw, lcl_msk;
    logic [HST_N-1:0] hst_raw, hst_msk;
    logic             lcl_style, hst_style;
    logic [OFS_W-1:0] ofs;

    assign ofs = reg_addr_i[OFS_W-1:0];

    irq_target #(.N(LCL_N), .DW(DW)) u_lcl (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (lcl_evt_i),
        .sel     (!reg_addr_i[TSEL]),
        .wr      (reg_wr_i),
        .ofs     (ofs),
        .wdata   (reg_wdata_i),
        .rdata   (lcl_rd),
        .raw_o   (lcl_raw),
        .msk_o   (lcl_msk),
        .style_o (lcl_style),
        .irq_o   (lcl_irq_o)
    );

    irq_target #(.N(HST_N), .DW(DW)) u_hst (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (hst_evt_i),
        .sel     (reg_addr_i[TSEL]),
        .wr      (reg_wr_i),
        .ofs     (ofs),
        .wdata   (reg_wdata_i),
        .rdata   (hst_rd),
        .raw_o   (hst_raw),
        .msk_o   (hst_msk),
        .style_o (hst_style),
        .irq_o   (hst_irq_o)
    );

    assign reg_rdata_o = reg_addr_i[TSEL] ? hst_rd : lcl_rd;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int unsigned LCL_N = 9,
    parameter int unsigned HST_N = 5,
    parameter int unsigned DW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LCL_N-1:0] lcl_evt_i,
    input logic [HST_N-1:0] hst_evt_i,
    input logic             reg_wr_i,
    input logic [3:0]       reg_addr_i,
    input logic [DW-1:0]    reg_wdata_i,
    input logic [LCL_N-1:0] lcl_raw,
    input logic [HST_N-1:0] hst_raw,
    input logic [LCL_N-1:0] lcl_msk,
    input logic [HST_N-1:0] hst_msk,
    input logic             lcl_style,
    input logic             hst_style,
    input logic             lcl_irq_o,
    input logic             hst_irq_o
);
    p_lcl_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|lcl_evt_i) |=> ((lcl_raw & $past(lcl_evt_i)) == $past(lcl_evt_i)));

    p_hst_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hst_evt_i) |=> ((hst_raw & $past(hst_evt_i)) == $past(hst_evt_i)));

    p_lcl_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == 4'h2) |=> ((lcl_raw & $past(lcl_raw)) == $past(lcl_raw)));

    p_hst_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == 4'hA) |=> ((hst_raw & $past(hst_raw)) == $past(hst_raw)));

    p_lcl_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == 4'h1) |=>
            ((lcl_raw & $past(reg_wdata_i[LCL_N-1:0])) == $past(reg_wdata_i[LCL_N-1:0])));

    p_lcl_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_irq_o |-> $past(|lcl_msk));

    p_hst_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hst_irq_o |-> $past(|hst_msk));

    p_lcl_level_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcl_style && (|lcl_msk)) |=> lcl_irq_o);

    p_hst_level_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_style && !(|hst_msk)) |=> !hst_irq_o);

    p_hst_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_style && $stable(hst_msk)) |=> !hst_irq_o);

    p_lcl_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lcl_style && $stable(lcl_msk)) |=> !lcl_irq_o);
endmodule

bind irq_aggregator irq_agg_chk #(.LCL_N(LCL_N), .HST_N(HST_N), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lcl_evt_i   (lcl_evt_i),
    .hst_evt_i   (hst_evt_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .lcl_raw     (lcl_raw),
    .hst_raw     (hst_raw),
    .lcl_msk     (lcl_msk),
    .hst_msk     (hst_msk),
    .lcl_style   (lcl_style),
    .hst_style   (hst_style),
    .lcl_irq_o   (lcl_irq_o),
    .hst_irq_o   (hst_irq_o)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  lcl_evt = '0;
    logic [4:0]  hst_evt = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        lcl_irq, hst_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .lcl_evt_i(lcl_evt), .hst_evt_i(hst_evt),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .lcl_irq_o(lcl_irq), .hst_irq_o(hst_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wreg(input logic [3:0] a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rchk(input string tag, input logic [3:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic t_reset;
        chk("R1 lcl_irq", {15'd0, lcl_irq}, 16'd0);
        chk("R1 hst_irq", {15'd0, hst_irq}, 16'd0);
        rchk("R1 lcl mask", 4'h0, 16'h0000);
        rchk("R1 lcl raw", 4'h4, 16'h0000);
        rchk("R1 hst style", 4'hB, 16'h0000);
        rchk("R1 hst masked", 4'hD, 16'h0000);
    endtask

    task automatic t_sticky_level;
        wreg(4'h0, 16'h0005);
        rchk("R5 lcl mask rb", 4'h0, 16'h0005);
        lcl_evt = 9'h003;
        @(negedge clk);
        lcl_evt = '0;
        rchk("R2 raw set", 4'h4, 16'h0003);
        rchk("R5 masked", 4'h5, 16'h0001);
        chk("R6 irq not yet", {15'd0, lcl_irq}, 16'd0);
        tick(1);
        chk("R6 irq high", {15'd0, lcl_irq}, 16'd1);
        tick(4);
        rchk("R2 raw sticky", 4'h4, 16'h0003);
        chk("R6 irq held", {15'd0, lcl_irq}, 16'd1);
    endtask

    task automatic t_clear;
        wreg(4'h2, 16'h0002);
        rchk("R3 clear one", 4'h4, 16'h0001);
        chk("R3 irq stays", {15'd0, lcl_irq}, 16'd1);
        wreg(4'h2, 16'h0001);
        rchk("R3 clear all", 4'h4, 16'h0000);
        tick(1);
        chk("R6 irq falls", {15'd0, lcl_irq}, 16'd0);
        lcl_evt = 9'h004;
        wr = 1'b1; addr = 4'h2; wdata = 16'h0004;
        @(negedge clk);
        wr = 1'b0; wdata = '0; lcl_evt = '0;
        rchk("R3 set wins", 4'h4, 16'h0004);
        wreg(4'h2, 16'h01FF);
        rchk("R3 cleared", 4'h4, 16'h0000);
    endtask

    task automatic t_force;
        wreg(4'h1, 16'h0100);
        rchk("R4 force raw", 4'h4, 16'h0100);
        rchk("R5 force masked", 4'h5, 16'h0000);
        tick(2);
        chk("R6 unmasked silent", {15'd0, lcl_irq}, 16'd0);
        wreg(4'h1, 16'h0001);
        tick(1);
        chk("R4 force irq", {15'd0, lcl_irq}, 16'd1);
        wreg(4'h2, 16'h0101);
        tick(1);
        chk("R4 irq cleared", {15'd0, lcl_irq}, 16'd0);
    endtask

    task automatic t_pulse;
        wreg(4'hB, 16'h0001);
        wreg(4'h8, 16'h001F);
        hst_evt = 5'h04;
        @(negedge clk);
        hst_evt = '0;
        chk("R7 pulse wait", {15'd0, hst_irq}, 16'd0);
        tick(1);
        chk("R7 pulse high", {15'd0, hst_irq}, 16'd1);
        tick(1);
        chk("R7 pulse one cycle", {15'd0, hst_irq}, 16'd0);
        tick(2);
        chk("R7 hold low", {15'd0, hst_irq}, 16'd0);
        hst_evt = 5'h10;
        @(negedge clk);
        hst_evt = '0;
        tick(1);
        chk("R7 second pulse", {15'd0, hst_irq}, 16'd1);
        hst_evt = 5'h04;
        @(negedge clk);
        hst_evt = '0;
        chk("R7 repeat low a", {15'd0, hst_irq}, 16'd0);
        tick(1);
        chk("R7 repeat low b", {15'd0, hst_irq}, 16'd0);
        rchk("R2 hst raw", 4'hC, 16'h0014);
        wreg(4'hB, 16'h0000);
        tick(1);
        chk("R6 hst level", {15'd0, hst_irq}, 16'd1);
    endtask

    task automatic t_indep_map;
        wreg(4'h8, 16'hFFFF);
        rchk("R9 hst mask width", 4'h8, 16'h001F);
        wreg(4'h0, 16'hFFFF);
        rchk("R9 lcl mask width", 4'h0, 16'h01FF);
        wreg(4'h2, 16'h01FF);
        rchk("R8 hst raw kept", 4'hC, 16'h0014);
        chk("R8 hst irq kept", {15'd0, hst_irq}, 16'd1);
        wreg(4'h0, 16'h0005);
        rchk("R8 hst mask kept", 4'h8, 16'h001F);
        rchk("R10 force reads 0", 4'h9, 16'h0000);
        rchk("R10 clear reads 0", 4'hA, 16'h0000);
        rchk("R10 ofs6 reads 0", 4'h6, 16'h0000);
        rchk("R10 ofs7 reads 0", 4'hF, 16'h0000);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset;
        t_sticky_level;
        t_clear;
        t_force;
        t_pulse;
        t_indep_map;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule